// File: doc/BRIEF.md
# Double-Buffered PWM Timer

This block is an 8-bit up-counting timer that drives one pulse-width-modulated output. A prescaler divides the system clock into timer ticks. The counter runs over a period of 2^n ticks, where n is 6, 7 or 8. An output flip-flop inverts at two points in each period: when the counter reaches the compare value, and when the counter wraps at the end of the period. Starting from a cleared flip-flop, the output is low for the first C ticks of every period and high for the remaining 2^n − C ticks.

The compare value is loaded through a write strobe. With double buffering enabled, a write goes into a shadow register, and the active compare register takes that value only at the next period wrap. A duty change made mid-period therefore never shortens or stretches the period in progress. With buffering disabled, a write takes effect at once. Direct clear and set controls force the output flip-flop to a known level. An inversion enable gates whether timer events may toggle the output.

Top module: `pwm_dbuf_timer`

## Requirements
- R1: After reset, `pwm_o` is 0, the counter is 0, and both the active and the buffered compare registers are 0.
- R2: The period is 2^n timer ticks, with n = 6, 7, 8 or 8 for `exp_sel_i` = 0, 1, 2 or 3. The counter wraps to 0 after reaching 2^n − 1, and the overflow event fires on that wrap.
- R3: One timer tick occurs every 1, 4, 16 or 64 clock cycles for `presc_sel_i` = 0, 1, 2 or 3.
- R4: With inversion enabled and the flip-flop cleared before start, the output is low for C ticks and high for 2^n − C ticks in every period, for 0 < C < 2^n. The flip-flop inverts on the tick where the counter becomes C, and again on the wrap.
- R5: With `dbuf_en_i` = 1, a compare write lands only in the buffer. The active compare value changes only at an overflow, so a write made mid-period first affects the following period.
- R6: With `dbuf_en_i` = 0, a compare write updates the active compare value on the next clock edge, and the period in progress uses the new value.
- R7: A compare value of 0 or one of at least 2^n causes no match toggle. A match that would coincide with the overflow is suppressed, so the output inverts only at each wrap and each phase lasts 2^n ticks.
- R8: While `run_i` is 0, the counter and the prescaler hold at 0 and the output does not change. Raising `run_i` restarts counting from 0.
- R9: `ff_clr_i` forces `pwm_o` to 0 on the next clock edge, and `ff_set_i` forces it to 1. If both are high, clear wins.
- R10: While `inv_en_i` is 0, match and overflow events leave `pwm_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | 1 = count, 0 = stop and clear the counter |
| exp_sel_i | input | 2 | Period exponent select (n = 6, 7, 8, 8) |
| presc_sel_i | input | 2 | Prescaler select (divide by 1, 4, 16, 64) |
| cmp_wr_i | input | 1 | Compare write strobe |
| cmp_data_i | input | 8 | Compare write data |
| dbuf_en_i | input | 1 | Double-buffer enable for compare writes |
| ff_clr_i | input | 1 | Clear output flip-flop |
| ff_set_i | input | 1 | Set output flip-flop |
| inv_en_i | input | 1 | Allow timer events to invert the output |
| pwm_o | output | 1 | PWM output |

## Verification
The hardest case to reach from the ports is a compare write that lands partway through a period. The write has to arrive after the wrap but before the counter reaches the new value, and only that timing tells buffered behaviour apart from immediate behaviour. To get there, the bench waits for the falling edge of the output, which marks the wrap. It then writes a compare value smaller than the old one three cycles later. It runs this once with buffering and once without. The scoreboard holds the two different phase sequences it expects, and the two results must differ exactly at that period. A compare value equal to 2^n for n = 6 makes the match land on the wrap tick, which exercises the suppression rule.

// File: rtl/pwm_tmr_pkg.sv
package pwm_tmr_pkg;
  localparam int unsigned CNT_W     = 8;
  localparam int unsigned EXP_SEL_W = 2;
  localparam int unsigned MIN_EXP   = 6;
  localparam int unsigned PSEL_W    = 2;
  // prescaler divides by 4^sel
  localparam int unsigned DIV_W     = 2 * ((1 << PSEL_W) - 1);

  typedef struct packed {
    logic match;
    logic ovf;
  } tmr_evt_t;
endpackage

// File: rtl/pwm_tmr_prescaler.sv
module pwm_tmr_prescaler
  import pwm_tmr_pkg::*;
#(
  parameter int unsigned SEL_W = PSEL_W,
  parameter int unsigned CW    = DIV_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  logic [CW-1:0] pcnt_q;
  logic [CW:0]   div_oh;
  logic [CW-1:0] div_m1;

  always_comb begin
    div_oh = (CW+1)'(1) << {sel_i, 1'b0};
    div_m1 = CW'(div_oh - (CW+1)'(1));
  end

  assign tick_o = run_i && (pcnt_q == div_m1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pcnt_q <= '0;
    else if (!run_i)  pcnt_q <= '0;
    else if (tick_o)  pcnt_q <= '0;
    else              pcnt_q <= pcnt_q + CW'(1);
  end
endmodule

// File: rtl/pwm_tmr_counter.sv
module pwm_tmr_counter
  import pwm_tmr_pkg::*;
#(
  parameter int unsigned W     = CNT_W,
  parameter int unsigned ESW   = EXP_SEL_W,
  parameter int unsigned E_MIN = MIN_EXP
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           run_i,
  input  logic           tick_i,
  input  logic [ESW-1:0] exp_sel_i,
  output logic [W-1:0]   cnt_o,
  output logic           ovf_o
);
  localparam int unsigned EW = $clog2(W + 1);

  logic [EW-1:0] exp_w;
  logic [W-1:0]  top_val;
  logic [W-1:0]  cnt_q;

  always_comb begin
    exp_w = EW'(E_MIN) + EW'(exp_sel_i);
    if (exp_w > EW'(W)) exp_w = EW'(W);
    top_val = W'(((W+1)'(1) << exp_w) - (W+1)'(1));
  end

  assign ovf_o = tick_i && (cnt_q == top_val);
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (ovf_o)   cnt_q <= '0;
    else if (tick_i)  cnt_q <= cnt_q + W'(1);
  end
endmodule

// File: rtl/pwm_tmr_compare.sv
module pwm_tmr_compare
  import pwm_tmr_pkg::*;
#(
  parameter int unsigned W = CNT_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] data_i,
  input  logic         dbuf_en_i,
  input  logic         tick_i,
  input  logic         ovf_i,
  input  logic [W-1:0] cnt_i,
  output logic         match_o,
  output logic [W-1:0] act_o,
  output logic [W-1:0] buf_o
);
  logic [W-1:0] act_q, buf_q;
  logic [W:0]   cnt_nxt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= '0;
      buf_q <= '0;
    end else begin
      if (wr_i) buf_q <= data_i;
      if (wr_i && !dbuf_en_i)      act_q <= data_i;
      else if (ovf_i && dbuf_en_i) act_q <= buf_q;
    end
  end

  // match when the counter is about to become the compare value; never on wrap
  assign cnt_nxt = {1'b0, cnt_i} + (W+1)'(1);
  assign match_o = tick_i && !ovf_i && (cnt_nxt == {1'b0, act_q});
  assign act_o   = act_q;
  assign buf_o   = buf_q;
endmodule

// File: rtl/pwm_tmr_outff.sv
module pwm_tmr_outff
  import pwm_tmr_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     clr_i,
  input  logic     set_i,
  input  logic     inv_en_i,
  input  tmr_evt_t evt_i,
  output logic     q_o
);
  logic q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       q_q <= 1'b0;
    else if (clr_i)    q_q <= 1'b0;
    else if (set_i)    q_q <= 1'b1;
    else if (inv_en_i && (evt_i.match || evt_i.ovf)) q_q <= ~q_q;
  end

  assign q_o = q_q;
endmodule

// File: rtl/pwm_dbuf_timer.sv
module pwm_dbuf_timer
  import pwm_tmr_pkg::*;
#(
  parameter int unsigned W     = CNT_W,
  parameter int unsigned ESW   = EXP_SEL_W,
  parameter int unsigned PSW   = PSEL_W,
  parameter int unsigned E_MIN = MIN_EXP
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           run_i,
  input  logic [ESW-1:0] exp_sel_i,
  input  logic [PSW-1:0] presc_sel_i,
  input  logic           cmp_wr_i,
  input  logic [W-1:0]   cmp_data_i,
  input  logic           dbuf_en_i,
  input  logic           ff_clr_i,
  input  logic           ff_set_i,
  input  logic           inv_en_i,
  output logic           pwm_o
);
  localparam int unsigned PDW = 2 * ((1 << PSW) - 1);

  logic         tick;
  logic [W-1:0] cnt;
  logic         ovf;
  logic         match;
  logic [W-1:0] cmp_act;
  logic [W-1:0] cmp_buf;
  tmr_evt_t     evt;

  pwm_tmr_prescaler #(.SEL_W(PSW), .CW(PDW)) u_presc (
    .clk_i (clk_i), .rst_ni(rst_ni), .run_i(run_i),
    .sel_i (presc_sel_i), .tick_o(tick)
  );

  pwm_tmr_counter #(.W(W), .ESW(ESW), .E_MIN(E_MIN)) u_cnt (
    .clk_i (clk_i), .rst_ni(rst_ni), .run_i(run_i), .tick_i(tick),
    .exp_sel_i(exp_sel_i), .cnt_o(cnt), .ovf_o(ovf)
  );

  pwm_tmr_compare #(.W(W)) u_cmp (
    .clk_i (clk_i), .rst_ni(rst_ni), .wr_i(cmp_wr_i), .data_i(cmp_data_i),
    .dbuf_en_i(dbuf_en_i), .tick_i(tick), .ovf_i(ovf), .cnt_i(cnt),
    .match_o(match), .act_o(cmp_act), .buf_o(cmp_buf)
  );

  assign evt.match = match;
  assign evt.ovf   = ovf;

  pwm_tmr_outff u_ff (
    .clk_i (clk_i), .rst_ni(rst_ni), .clr_i(ff_clr_i), .set_i(ff_set_i),
    .inv_en_i(inv_en_i), .evt_i(evt), .q_o(pwm_o)
  );
endmodule

// File: rtl/pwm_dbuf_timer_checker.sv
module pwm_dbuf_timer_checker #(
  parameter int unsigned W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         run_i,
  input logic         cmp_wr_i,
  input logic [W-1:0] cmp_data_i,
  input logic         dbuf_en_i,
  input logic         ff_clr_i,
  input logic         ff_set_i,
  input logic         inv_en_i,
  input logic         pwm_o,
  input logic         tick,
  input logic         ovf,
  input logic         match,
  input logic [W-1:0] cnt,
  input logic [W-1:0] cmp_act
);
  assert_wrap_to_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf |=> (cnt == '0));

  assert_hold_between_ticks_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !tick) |=> $stable(cnt));

  assert_buffered_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbuf_en_i && !ovf) |=> $stable(cmp_act));

  assert_direct_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_wr_i && !dbuf_en_i) |=> (cmp_act == $past(cmp_data_i)));

  assert_no_double_toggle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(match && ovf));

  assert_stop_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt == '0));

  assert_clear_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ff_clr_i |=> !pwm_o);

  assert_set_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ff_set_i && !ff_clr_i) |=> pwm_o);

  assert_inv_gated_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inv_en_i && !ff_clr_i && !ff_set_i) |=> $stable(pwm_o));
endmodule

bind pwm_dbuf_timer pwm_dbuf_timer_checker #(.W(W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_i), .cmp_wr_i(cmp_wr_i),
  .cmp_data_i(cmp_data_i), .dbuf_en_i(dbuf_en_i), .ff_clr_i(ff_clr_i),
  .ff_set_i(ff_set_i), .inv_en_i(inv_en_i), .pwm_o(pwm_o), .tick(tick),
  .ovf(ovf), .match(match), .cnt(cnt), .cmp_act(cmp_act)
);

// File: tb/pwm_dbuf_timer_bench.sv
`timescale 1ns/1ps
module pwm_dbuf_timer_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       run_i = 1'b0;
  logic [1:0] exp_sel_i = '0;
  logic [1:0] presc_sel_i = '0;
  logic       cmp_wr_i = 1'b0;
  logic [7:0] cmp_data_i = '0;
  logic       dbuf_en_i = 1'b0;
  logic       ff_clr_i = 1'b0;
  logic       ff_set_i = 1'b0;
  logic       inv_en_i = 1'b0;
  logic       pwm_o;

  typedef struct {
    int    level;
    int    len;
    string tag;
  } phase_t;

  phase_t exp_q[$];
  int checks = 0, errors = 0;
  bit mon_en = 1'b0;
  int skip = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  pwm_dbuf_timer u_pwm_dbuf_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_i), .exp_sel_i(exp_sel_i),
    .presc_sel_i(presc_sel_i), .cmp_wr_i(cmp_wr_i), .cmp_data_i(cmp_data_i),
    .dbuf_en_i(dbuf_en_i), .ff_clr_i(ff_clr_i), .ff_set_i(ff_set_i),
    .inv_en_i(inv_en_i), .pwm_o(pwm_o)
  );

  task automatic chk(bit ok, string tag, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  task automatic push(int lvl, int len, string tag);
    phase_t p;
    p.level = lvl; p.len = len; p.tag = tag;
    exp_q.push_back(p);
  endtask

  // monitor: measures each completed output phase in clock cycles
  initial begin
    int   len;
    logic prev;
    len = 0; prev = 1'b0;
    forever begin
      @(negedge clk_i);
      if (!rst_ni) begin
        len = 0; prev = pwm_o;
      end else if (pwm_o !== prev) begin
        if (mon_en) begin
          if (skip > 0) skip--;
          else if (exp_q.size() > 0) begin
            phase_t e;
            e = exp_q.pop_front();
            checks++;
            if (int'(prev) != e.level || len != e.len) begin
              errors++;
              $display("FAIL %s: phase level %0d len %0d, expected level %0d len %0d",
                       e.tag, prev, len, e.level, e.len);
            end
          end
        end
        len = 1; prev = pwm_o;
      end else len++;
    end
  end

  task automatic write_cmp(logic [7:0] v);
    @(negedge clk_i); cmp_wr_i = 1'b1; cmp_data_i = v;
    @(negedge clk_i); cmp_wr_i = 1'b0;
  endtask

  task automatic halt();
    @(negedge clk_i); run_i = 1'b0; mon_en = 1'b0;
  endtask

  // stop, clear the flip-flop, load config, arm scoreboard, start
  task automatic start(logic [1:0] es, logic [1:0] ps, logic [7:0] c, logic db);
    halt();
    ff_clr_i = 1'b1;
    @(negedge clk_i); ff_clr_i = 1'b0;
    exp_sel_i = es; presc_sel_i = ps; dbuf_en_i = 1'b0; inv_en_i = 1'b1;
    write_cmp(c);
    dbuf_en_i = db;
    repeat (2) @(negedge clk_i);
    skip = 1; mon_en = 1'b1; run_i = 1'b1;
  endtask

  task automatic drain();
    while (exp_q.size() > 0) @(negedge clk_i);
    halt();
  endtask

  task automatic wait_level(logic lvl);
    do @(negedge clk_i); while (pwm_o !== lvl);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int k;
    repeat (3) @(negedge clk_i);
    chk(pwm_o === 1'b0, "R1", "pwm_o in reset", int'(pwm_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(pwm_o === 1'b0, "R1", "pwm_o after reset", int'(pwm_o), 0);

    // R4 and R2: n=7, C=0x5A, divide by 1
    start(2'd1, 2'd0, 8'h5A, 1'b0);
    for (int i = 0; i < 3; i++) begin push(1, 38, "R4"); push(0, 90, "R2"); end
    drain();

    // R2 with n=8, R4
    start(2'd2, 2'd0, 8'd200, 1'b1);
    for (int i = 0; i < 2; i++) begin push(1, 56, "R2"); push(0, 200, "R4"); end
    drain();

    // R2: exp_sel 3 behaves as n=8
    start(2'd3, 2'd0, 8'd100, 1'b0);
    push(1, 156, "R2"); push(0, 100, "R2");
    drain();

    // R3: divide by 16, n=6, C=16
    start(2'd0, 2'd2, 8'd16, 1'b0);
    for (int i = 0; i < 2; i++) begin push(1, 48*16, "R3"); push(0, 16*16, "R3"); end
    drain();

    // R3: divide by 4
    start(2'd0, 2'd1, 8'd10, 1'b0);
    push(1, 54*4, "R3"); push(0, 10*4, "R3");
    drain();

    // R5: buffered mid-period write takes effect from the next period
    start(2'd0, 2'd0, 8'd40, 1'b1);
    push(1, 24, "R5"); push(0, 40, "R5"); push(1, 24, "R5");
    push(0, 10, "R5"); push(1, 54, "R5");
    wait_level(1'b1); wait_level(1'b0);
    repeat (2) @(negedge clk_i);
    write_cmp(8'd10);
    drain();

    // R6: unbuffered mid-period write applies at once
    start(2'd0, 2'd0, 8'd40, 1'b0);
    push(1, 24, "R6"); push(0, 10, "R6"); push(1, 54, "R6");
    wait_level(1'b1); wait_level(1'b0);
    repeat (2) @(negedge clk_i);
    write_cmp(8'd10);
    drain();

    // R7: C=0 and C=2^n give overflow-only toggling
    start(2'd0, 2'd0, 8'd0, 1'b0);
    for (int i = 0; i < 2; i++) begin push(1, 64, "R7"); push(0, 64, "R7"); end
    drain();
    start(2'd0, 2'd0, 8'd64, 1'b0);
    for (int i = 0; i < 2; i++) begin push(1, 64, "R7"); push(0, 64, "R7"); end
    drain();

    // R8: stop holds output, restart counts from 0
    start(2'd0, 2'd0, 8'd20, 1'b0);
    mon_en = 1'b0;
    wait_level(1'b1); wait_level(1'b0); wait_level(1'b1);
    repeat (5) @(negedge clk_i);
    run_i = 1'b0;
    k = 0;
    for (int i = 0; i < 100; i++) begin @(negedge clk_i); if (pwm_o !== 1'b1) k++; end
    chk(k == 0, "R8", "samples off high while stopped", k, 0);
    run_i = 1'b1;
    k = 0;
    do begin @(negedge clk_i); k++; end while (pwm_o === 1'b1 && k < 1000);
    chk(k == 20, "R8", "cycles from restart to match toggle", k, 20);
    halt();

    // R9: set, clear, and clear winning over set
    @(negedge clk_i); ff_set_i = 1'b1;
    @(negedge clk_i); ff_set_i = 1'b0;
    chk(pwm_o === 1'b1, "R9", "pwm_o after set", int'(pwm_o), 1);
    ff_clr_i = 1'b1;
    @(negedge clk_i); ff_clr_i = 1'b0;
    chk(pwm_o === 1'b0, "R9", "pwm_o after clear", int'(pwm_o), 0);
    ff_set_i = 1'b1;
    @(negedge clk_i);
    ff_set_i = 1'b1; ff_clr_i = 1'b1;
    @(negedge clk_i); ff_set_i = 1'b0; ff_clr_i = 1'b0;
    chk(pwm_o === 1'b0, "R9", "pwm_o with clear and set", int'(pwm_o), 0);

    // R10: inversion disabled, events do not move the output
    inv_en_i = 1'b0; exp_sel_i = 2'd0; presc_sel_i = 2'd0;
    write_cmp(8'd5);
    @(negedge clk_i); ff_set_i = 1'b1;
    @(negedge clk_i); ff_set_i = 1'b0; run_i = 1'b1;
    k = 0;
    for (int i = 0; i < 200; i++) begin @(negedge clk_i); if (pwm_o !== 1'b1) k++; end
    chk(k == 0, "R10", "samples off high with inversion off", k, 0);
    halt();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule